// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block collects event pulses from three sources (receive, transmit and miscellaneous) into three groups of 32-bit cause registers and turns them into one host interrupt line. A group has a cause register, a mask that software changes only through separate set and clear ports, and a per-bit clear-mode register. Each cause bit can be cleared either when software reads it or when software writes a 1 to it.

Each group reports whether any of its unmasked cause bits is pending. These three flags form a small summary word that clears when read. A software mask register sits over the summary and decides which groups may drive the host interrupt line. The host reaches every register through a simple single-cycle word-addressed read/write bus. Read data is combinational, and the side effects of a read take place at the clock edge that ends the access.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset every cause bit is 0, every group mask bit is 1, every clear-mode bit is 0 (write-one-to-clear), the summary word is 0, the software mask is all ones and irq_o is low.
- R2: A pulse on an event bit sets the matching cause bit at the next clock edge. When an event and a clear of the same bit meet in one cycle, the bit stays set.
- R3: For a cause bit whose clear-mode bit is 0, writing 1 to it at the cause offset clears it. Writing 0 leaves it unchanged, and reading the cause register does not change it.
- R4: For a cause bit whose clear-mode bit is 1, reading the cause register returns it and then clears it. Writes to that bit at the cause offset are ignored. The clear-mode register reads back as written.
- R5: A write to the mask-set offset sets every mask bit that is 1 in the data. A write to the mask-clear offset clears every such mask bit. The mask offset reads the current mask, and both port offsets read as 0.
- R6: The masked-value offset reads the cause bits that are pending and not masked (cause AND NOT mask).
- R7: Bit g of the summary word (g = 0 receive, 1 transmit, 2 miscellaneous) is 1 while group g has any unmasked pending cause bit. Its upper bits read 0.
- R8: A summary bit that became set stays set until the summary word is read. The read clears it, and it is set again only if the group is still active.
- R9: irq_o is a register. One cycle after any group is active while its software-mask bit (bit g) is 0, irq_o is 1. It is 0 one cycle after every such pairing is gone. An all-ones software mask blocks every group.
- R10: Word address = group*8 + offset, with offsets cause 0, mask 1, mask-set 2, mask-clear 3, clear-mode 4, masked-value 5. The summary word is at 24 and the software mask at 25. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 96 | Event pulses, group g at bits [g*32 +: 32] |
| req_i | input | 1 | Host access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Host interrupt line |

## Verification
The in-line assertions check on every cycle that:
- events always set their cause bits and no bit is set without one;
- a clear-on-read access empties the selected bits;
- mask set and clear writes land as written;
- a summary read with no active group empties the summary;
- irq_o follows the gated group activity and is silenced by an all-ones software mask.

Only the bench scenarios can show some of the behaviour:
- the read-back values across the address map;
- the difference between the two clear modes on the same access sequence;
- an event winning against a simultaneous write-back;
- the sticky-then-cleared behaviour of the summary word;
- that the group bits reach the summary in the right order.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
package irq_bank_pkg;
  localparam int unsigned REG_SEL_W = 3;  // offsets per group

  typedef enum logic [REG_SEL_W-1:0] {
    REG_CAUSE = 3'd0,
    REG_MASK  = 3'd1,
    REG_MSET  = 3'd2,
    REG_MCLR  = 3'd3,
    REG_MODE  = 3'd4,
    REG_MVAL  = 3'd5
  } grp_reg_e;
endpackage

// File: rtl/irq_cause_group.sv
`timescale 1ns/1ps
module irq_cause_group
  import irq_bank_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic          sel_i,
  input  logic          we_i,
  input  grp_reg_e      reg_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          active_o
);
  logic [DW-1:0] cause_q, mask_q, mode_q;
  logic [DW-1:0] clr, cause_d, mask_d, mode_d;
  logic rd_cause, wr_cause, wr_mset, wr_mclr, wr_mode;

  assign rd_cause = sel_i && !we_i && (reg_i == REG_CAUSE);
  assign wr_cause = sel_i &&  we_i && (reg_i == REG_CAUSE);
  assign wr_mset  = sel_i &&  we_i && (reg_i == REG_MSET);
  assign wr_mclr  = sel_i &&  we_i && (reg_i == REG_MCLR);
  assign wr_mode  = sel_i &&  we_i && (reg_i == REG_MODE);

  always_comb begin
    clr = '0;
    if (wr_cause) clr = clr | (wdata_i & ~mode_q);
    if (rd_cause) clr = clr | mode_q;
    cause_d = (cause_q & ~clr) | evt_i;  // event beats clear
    mask_d  = mask_q;
    if (wr_mset) mask_d = mask_q | wdata_i;
    if (wr_mclr) mask_d = mask_q & ~wdata_i;
    mode_d  = wr_mode ? wdata_i : mode_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
    end else begin
      cause_q <= cause_d;
      mask_q  <= mask_d;
      mode_q  <= mode_d;
    end
  end

  always_comb begin
    case (reg_i)
      REG_CAUSE: rdata_o = cause_q;
      REG_MASK:  rdata_o = mask_q;
      REG_MODE:  rdata_o = mode_q;
      REG_MVAL:  rdata_o = cause_q & ~mask_q;
      default:   rdata_o = '0;
    endcase
  end

  assign active_o = |(cause_q & ~mask_q);

  // R2
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));
  // R2
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_q & ~$past(cause_q) & ~$past(evt_i)) == '0));
  // R4
  cor_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cause |=> ((cause_q & $past(mode_q) & ~$past(evt_i)) == '0));
  // R5
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mset |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  // R5
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mclr |=> ((mask_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/irq_summary.sv
`timescale 1ns/1ps
module irq_summary #(
  parameter int unsigned NG = 3,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NG-1:0] active_i,
  input  logic          rd_sum_i,
  input  logic          wr_swm_i,
  input  logic [DW-1:0] wdata_i,
  output logic [NG-1:0] sum_o,
  output logic [DW-1:0] swm_o,
  output logic          irq_o
);
  logic [NG-1:0] sum_q;
  logic [DW-1:0] swm_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      swm_q <= '1;
      irq_q <= 1'b0;
    end else begin
      sum_q <= (rd_sum_i ? '0 : sum_q) | active_i;
      if (wr_swm_i) swm_q <= wdata_i;
      irq_q <= |(active_i & ~swm_q[NG-1:0]);
    end
  end

  assign sum_o = sum_q | active_i;
  assign swm_o = swm_q;
  assign irq_o = irq_q;

  // R9
  irq_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&swm_q[NG-1:0]) |=> !irq_o);
  // R9
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(active_i & ~swm_q[NG-1:0])) |=> irq_o);
  // R8
  sum_cor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sum_i && (active_i == '0)) |=> (sum_q == '0));
endmodule

// File: rtl/irq_cause_bank.sv
`timescale 1ns/1ps
module irq_cause_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NG = 3,
  parameter int unsigned AW = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NG*DW-1:0] evt_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o
);
  localparam int unsigned GIW      = AW - REG_SEL_W;
  localparam int unsigned SUM_ADDR = NG << REG_SEL_W;
  localparam int unsigned SWM_ADDR = SUM_ADDR + 1;

  logic [GIW-1:0] grp_idx;
  grp_reg_e       reg_sel;
  logic [NG-1:0]  active;
  logic [DW-1:0]  grp_rdata [NG];
  logic [NG-1:0]  sum_val;
  logic [DW-1:0]  swm_val;
  logic           hit_sum, hit_swm;

  assign grp_idx = addr_i[AW-1:REG_SEL_W];
  assign reg_sel = grp_reg_e'(addr_i[REG_SEL_W-1:0]);
  assign hit_sum = (int'(addr_i) == SUM_ADDR);
  assign hit_swm = (int'(addr_i) == SWM_ADDR);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    irq_cause_group #(.DW(DW)) i_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i[g*DW +: DW]),
      .sel_i    (req_i && (int'(grp_idx) == g)),
      .we_i     (we_i),
      .reg_i    (reg_sel),
      .wdata_i  (wdata_i),
      .rdata_o  (grp_rdata[g]),
      .active_o (active[g])
    );
  end

  irq_summary #(.NG(NG), .DW(DW)) i_sum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .rd_sum_i (req_i && !we_i && hit_sum),
    .wr_swm_i (req_i && we_i && hit_swm),
    .wdata_i  (wdata_i),
    .sum_o    (sum_val),
    .swm_o    (swm_val),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NG; g++)
      if (int'(grp_idx) == g) rdata_o = grp_rdata[g];
    if (hit_sum) begin
      rdata_o = '0;
      rdata_o[NG-1:0] = sum_val;
    end
    if (hit_swm) rdata_o = swm_val;
  end
endmodule

// File: tb/test_irq_cause_bank.sv
`timescale 1ns/1ps
module test_irq_cause_bank;
  localparam int DW = 32;
  localparam int NG = 3;
  localparam int AW = 5;
  localparam int RX = 0, TX = 1, MS = 2;
  localparam int O_CAUSE = 0, O_MASK = 1, O_MSET = 2, O_MCLR = 3, O_MODE = 4, O_MVAL = 5;
  localparam int A_SUM = 24, A_SWM = 25;

  logic clk = 0;
  logic rst_n = 0;
  logic [NG*DW-1:0] evt = '0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #2.5 clk = ~clk;

  irq_cause_bank #(.DW(DW), .NG(NG), .AW(AW)) i_irq_cause_bank (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [AW-1:0] ga(int g, int o);
    return AW'(g * 8 + o);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    step();
    req = 0; we = 0;
  endtask

  // driver: push expected value, issue the read
  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
    req = 1; we = 0; addr = a;
    step();
    req = 0;
  endtask

  task automatic pulse(int g, logic [DW-1:0] b);
    evt[g*DW +: DW] = b;
    step();
    evt = '0;
  endtask

  task automatic wr_with_evt(logic [AW-1:0] a, logic [DW-1:0] d, int g, logic [DW-1:0] b);
    req = 1; we = 1; addr = a; wdata = d; evt[g*DW +: DW] = b;
    step();
    req = 0; we = 0; evt = '0;
  endtask

  task automatic chk_irq(logic e, string t);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq_o act=%0b exp=%0b", t, irq, e);
    end
  endtask

  // monitor: pop and compare at mid-cycle
  always @(negedge clk) begin
    if (rst_n && req && !we) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s addr=%0d act=%h exp=%h", t, addr, rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(ga(RX, O_CAUSE), 32'h0, "R1 cause");
    rd(ga(RX, O_MASK), 32'hFFFF_FFFF, "R1 mask");
    rd(ga(TX, O_MODE), 32'h0, "R1 mode");
    rd(A_SUM, 32'h0, "R1 summary");
    rd(A_SWM, 32'hFFFF_FFFF, "R1 swmask");
    // R2 events set cause while masked
    pulse(RX, 32'h9);
    rd(ga(RX, O_CAUSE), 32'h9, "R2 set");
    rd(ga(RX, O_MVAL), 32'h0, "R6 masked");
    rd(A_SUM, 32'h0, "R7 masked group");
    // R5 unmask bit 0
    wr(ga(RX, O_MCLR), 32'h1);
    rd(ga(RX, O_MASK), 32'hFFFF_FFFE, "R5 mask clr");
    rd(ga(RX, O_MSET), 32'h0, "R10 set port reads 0");
    rd(ga(RX, O_MVAL), 32'h1, "R6 mval");
    rd(A_SUM, 32'h1, "R7 rx bit0");
    step(); step();
    chk_irq(1'b0, "R9 blocked");
    // R9 enable groups
    wr(A_SWM, 32'hFFFF_FFF8);
    step(); step();
    chk_irq(1'b1, "R9 enabled");
    rd(A_SUM, 32'h1, "R8 active");
    rd(A_SUM, 32'h1, "R8 reset while active");
    // R3 write-one-to-clear
    wr(ga(RX, O_CAUSE), 32'h1);
    rd(ga(RX, O_CAUSE), 32'h8, "R3 w1c");
    rd(ga(RX, O_CAUSE), 32'h8, "R3 read keeps");
    rd(A_SUM, 32'h1, "R8 sticky");
    rd(A_SUM, 32'h0, "R8 cleared");
    step();
    chk_irq(1'b0, "R9 dropped");
    // R4 clear-on-read on tx
    wr(ga(TX, O_MODE), 32'hFFFF_FFFF);
    rd(ga(TX, O_MODE), 32'hFFFF_FFFF, "R4 mode rb");
    pulse(TX, 32'h20);
    rd(ga(TX, O_CAUSE), 32'h20, "R4 first read");
    rd(ga(TX, O_CAUSE), 32'h0, "R4 cleared");
    pulse(TX, 32'h40);
    wr(ga(TX, O_CAUSE), 32'h40);
    rd(ga(TX, O_CAUSE), 32'h40, "R4 write ignored");
    rd(ga(TX, O_CAUSE), 32'h0, "R4 cleared again");
    // R2 event beats simultaneous clear
    pulse(MS, 32'h4);
    wr_with_evt(ga(MS, O_CAUSE), 32'h4, MS, 32'h4);
    rd(ga(MS, O_CAUSE), 32'h4, "R2 event wins");
    wr(ga(MS, O_CAUSE), 32'h4);
    rd(ga(MS, O_CAUSE), 32'h0, "R3 cleared");
    // R7 group order, misc -> bit 2
    pulse(MS, 32'h4);
    wr(ga(MS, O_MCLR), 32'h4);
    rd(ga(MS, O_MVAL), 32'h4, "R6 misc");
    rd(A_SUM, 32'h4, "R7 misc bit2");
    step();
    chk_irq(1'b1, "R9 misc");
    wr(A_SWM, 32'hFFFF_FFFF);
    step(); step();
    chk_irq(1'b0, "R9 all ones");
    // R5 mask set
    wr(ga(MS, O_MSET), 32'h4);
    rd(ga(MS, O_MASK), 32'hFFFF_FFFF, "R5 mask set");
    rd(ga(MS, O_MVAL), 32'h0, "R6 remasked");
    rd(A_SUM, 32'h4, "R8 sticky misc");
    rd(A_SUM, 32'h0, "R8 cleared misc");
    rd(AW'(31), 32'h0, "R10 unmapped");
    step(); step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule